// File: doc/BRIEF.md
# Frame Pointer Guard for a RAM Time-Base Corrector

This block manages the two frame indices of a ring of sixteen frame slots in a RAM time-base corrector. One side fills the ring at a rate set by timing recovered from the disc. The other side empties it at a rate set by a crystal. The speed wobble of the disc is taken up by the varying number of frames held between the two. Both frame strobes arrive already synchronized into the single system clock. The block turns each index into a RAM base address and adds a byte offset within the 32-byte frame.

The block tracks the write lead, which is the number of frames the write index is ahead of the read index, taken modulo 16. If the lead goes past 14 frames, the write index is forced onto the read index and an overflow flag is raised. This lets the ring recover without stalling either side. A per-slot written map makes sure that slots left stale by such a jump are never presented to the read side as good data.

Top module: `frame_ptr_guard`

## Requirements
- R1: On a clock edge where `wr_frame_i` is high and no reload occurs, `wr_ptr_o` advances by one modulo 16. With `wr_frame_i` low and no reload, it holds.
- R2: `rd_ptr_o` advances by one modulo 16 on each edge where `rd_frame_i` is high, holds otherwise, and is never changed by a reload.
- R3: The lead is (next write index − next read index) mod 16, giving a value from 0 to 15. Here the next indices already include that edge's strobes. When this lead is greater than 14, the write index is loaded with the next read index instead, so the lead becomes 0.
- R4: `ovf_o` goes high on the edge that performs a reload. It stays high until the first later edge that has `wr_frame_i` high and does not reload, and that edge clears it. A reload while it is high keeps it high.
- R5: Each of the 16 slots has a written mark. A write strobe sets the mark of the slot at the current write index. A read strobe then clears the mark of the slot at the current read index. A reload clears every mark and takes priority. `rd_valid_o` shows the mark of the slot at `rd_ptr_o`.
- R6: `wr_addr_o` equals `wr_ptr_o`·32 + `wr_ofs_i`, and `rd_addr_o` equals `rd_ptr_o`·32 + `rd_ofs_i`. Both are combinational in the offset.
- R7: After reset, `wr_ptr_o` = 8, `rd_ptr_o` = 0, `ovf_o` = 0, and every slot mark is clear, so `rd_valid_o` = 0.
- R8: When both strobes arrive on the same edge, both advances are applied before the lead is tested. Equal strobes therefore leave the lead unchanged and never cause a reload by themselves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_frame_i | input | 1 | Write-frame strobe, one cycle per frame |
| rd_frame_i | input | 1 | Read-frame strobe, one cycle per frame |
| wr_ofs_i | input | 5 | Byte offset inside the write frame |
| rd_ofs_i | input | 5 | Byte offset inside the read frame |
| wr_ptr_o | output | 4 | Write frame index |
| rd_ptr_o | output | 4 | Read frame index |
| wr_addr_o | output | 9 | Write RAM byte address |
| rd_addr_o | output | 9 | Read RAM byte address |
| ovf_o | output | 1 | Overflow flag, lasts one write-frame interval |
| rd_valid_o | output | 1 | Slot at the read index holds fresh data |

## Verification
The bench first drives long runs of write-only strobes and then long runs of read-only strobes. These push the lead past 14 from both directions: the writer laps the reader, and the reader overtakes the writer. A design that tested the lead before applying the increments, or that used a signed distance, would reload one frame late or never. Runs of simultaneous strobes and biased pseudo-random traffic probe two further cases. One is overflow held through repeated reloads, which a design that cleared on any write strobe would drop too early. The other is a slot marked and cleared on the same edge, where a design that let the write mark win would report stale data as valid. Offsets are swept over all 32 values so that any shift or carry error in the address concatenation shows up.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

    localparam int unsigned FPG_PTR_W      = 4;
    localparam int unsigned FPG_OFS_W      = 5;
    localparam int unsigned FPG_DEPTH      = 1 << FPG_PTR_W;
    localparam int unsigned FPG_ADDR_W     = FPG_PTR_W + FPG_OFS_W;
    localparam int unsigned FPG_LEAD_LIMIT = 14;
    localparam int unsigned FPG_RESET_LEAD = 8;

    typedef struct packed {
        logic [FPG_PTR_W-1:0] wr_ptr;
        logic [FPG_PTR_W-1:0] rd_ptr;
        logic                 ovf;
        logic [FPG_DEPTH-1:0] marks;
    } fpg_state_t;

endpackage

// File: rtl/fpg_lead_calc.sv
module fpg_lead_calc
    import fpg_pkg::*;
(
    input  logic [FPG_PTR_W-1:0] wr_ptr_i,
    input  logic [FPG_PTR_W-1:0] rd_ptr_i,
    input  logic                 wr_stb_i,
    input  logic                 rd_stb_i,
    output logic [FPG_PTR_W-1:0] wr_next_o,
    output logic [FPG_PTR_W-1:0] rd_next_o,
    output logic                 reload_o
);

    localparam logic [FPG_PTR_W-1:0] LIMIT_V = FPG_PTR_W'(FPG_LEAD_LIMIT);

    logic [FPG_PTR_W-1:0] wr_inc;
    logic [FPG_PTR_W-1:0] rd_inc;
    logic [FPG_PTR_W-1:0] lead;

    always_comb begin
        // Both advances first, then the distance test on the advanced pair.
        wr_inc    = wr_ptr_i + {{(FPG_PTR_W-1){1'b0}}, wr_stb_i};
        rd_inc    = rd_ptr_i + {{(FPG_PTR_W-1){1'b0}}, rd_stb_i};
        lead      = wr_inc - rd_inc;
        reload_o  = (lead > LIMIT_V);
        wr_next_o = reload_o ? rd_inc : wr_inc;
        rd_next_o = rd_inc;
    end

endmodule

// File: rtl/fpg_valid_map.sv
module fpg_valid_map
    import fpg_pkg::*;
(
    input  logic [FPG_DEPTH-1:0] marks_i,
    input  logic [FPG_PTR_W-1:0] wr_ptr_i,
    input  logic [FPG_PTR_W-1:0] rd_ptr_i,
    input  logic                 wr_stb_i,
    input  logic                 rd_stb_i,
    input  logic                 reload_i,
    output logic [FPG_DEPTH-1:0] marks_o,
    output logic                 rd_hit_o
);

    for (genvar g = 0; g < FPG_DEPTH; g++) begin : g_slot
        logic set_s;
        logic clr_s;
        always_comb begin
            set_s = wr_stb_i && (wr_ptr_i == FPG_PTR_W'(g));
            clr_s = rd_stb_i && (rd_ptr_i == FPG_PTR_W'(g));
            // Priority: reload wipes, then read consumption, then write fill.
            if (reload_i)   marks_o[g] = 1'b0;
            else if (clr_s) marks_o[g] = 1'b0;
            else if (set_s) marks_o[g] = 1'b1;
            else            marks_o[g] = marks_i[g];
        end
    end

    assign rd_hit_o = marks_i[rd_ptr_i];

endmodule

// File: rtl/frame_ptr_guard.sv
module frame_ptr_guard
    import fpg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_frame_i,
    input  logic                  rd_frame_i,
    input  logic [FPG_OFS_W-1:0]  wr_ofs_i,
    input  logic [FPG_OFS_W-1:0]  rd_ofs_i,
    output logic [FPG_PTR_W-1:0]  wr_ptr_o,
    output logic [FPG_PTR_W-1:0]  rd_ptr_o,
    output logic [FPG_ADDR_W-1:0] wr_addr_o,
    output logic [FPG_ADDR_W-1:0] rd_addr_o,
    output logic                  ovf_o,
    output logic                  rd_valid_o
);

    localparam logic [FPG_PTR_W-1:0] RST_WR = FPG_PTR_W'(FPG_RESET_LEAD);
    localparam logic [FPG_PTR_W-1:0] LIMIT_V = FPG_PTR_W'(FPG_LEAD_LIMIT);

    fpg_state_t state_d;
    fpg_state_t state_q;

    logic [FPG_PTR_W-1:0] wr_next;
    logic [FPG_PTR_W-1:0] rd_next;
    logic                 reload;
    logic [FPG_DEPTH-1:0] marks_next;
    logic                 rd_hit;

    fpg_lead_calc u_lead (
        .wr_ptr_i (state_q.wr_ptr),
        .rd_ptr_i (state_q.rd_ptr),
        .wr_stb_i (wr_frame_i),
        .rd_stb_i (rd_frame_i),
        .wr_next_o(wr_next),
        .rd_next_o(rd_next),
        .reload_o (reload)
    );

    fpg_valid_map u_map (
        .marks_i (state_q.marks),
        .wr_ptr_i(state_q.wr_ptr),
        .rd_ptr_i(state_q.rd_ptr),
        .wr_stb_i(wr_frame_i),
        .rd_stb_i(rd_frame_i),
        .reload_i(reload),
        .marks_o (marks_next),
        .rd_hit_o(rd_hit)
    );

    always_comb begin
        state_d        = state_q;
        state_d.wr_ptr = wr_next;
        state_d.rd_ptr = rd_next;
        state_d.marks  = marks_next;
        if (reload)
            state_d.ovf = 1'b1;
        else if (wr_frame_i)
            state_d.ovf = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.wr_ptr <= RST_WR;
            state_q.rd_ptr <= '0;
            state_q.ovf    <= 1'b0;
            state_q.marks  <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign wr_ptr_o   = state_q.wr_ptr;
    assign rd_ptr_o   = state_q.rd_ptr;
    assign wr_addr_o  = {state_q.wr_ptr, wr_ofs_i};
    assign rd_addr_o  = {state_q.rd_ptr, rd_ofs_i};
    assign ovf_o      = state_q.ovf;
    assign rd_valid_o = rd_hit;

    AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_frame_i && !reload) |=> (wr_ptr_o == $past(wr_ptr_o) + 1'b1)); // R1
    AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_frame_i |=> (rd_ptr_o == $past(rd_ptr_o) + 1'b1)); // R2
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_frame_i |=> $stable(rd_ptr_o)); // R2
    AST_LEAD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (FPG_PTR_W'(wr_ptr_o - rd_ptr_o) <= LIMIT_V)); // R3
    AST_RELOAD_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> (wr_ptr_o == rd_ptr_o)); // R3
    AST_OVF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && wr_frame_i && !reload) |=> !ovf_o); // R4
    AST_STALE_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> !rd_valid_o); // R5
    AST_EVEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_frame_i && rd_frame_i) |-> !reload); // R8

endmodule

// File: tb/frame_ptr_guard_bench.sv
module frame_ptr_guard_bench;
    import fpg_pkg::*;

    localparam time CLK_PERIOD = 10ns;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  wr_frame_i = 1'b0;
    logic                  rd_frame_i = 1'b0;
    logic [FPG_OFS_W-1:0]  wr_ofs_i = '0;
    logic [FPG_OFS_W-1:0]  rd_ofs_i = '0;
    logic [FPG_PTR_W-1:0]  wr_ptr_o;
    logic [FPG_PTR_W-1:0]  rd_ptr_o;
    logic [FPG_ADDR_W-1:0] wr_addr_o;
    logic [FPG_ADDR_W-1:0] rd_addr_o;
    logic                  ovf_o;
    logic                  rd_valid_o;

    int checks = 0;
    int fails  = 0;

    int m_wr, m_rd, m_ovf;
    int m_mark [16];
    logic [15:0] lfsr = 16'hACE1;

    frame_ptr_guard u_frame_ptr_guard (
        .clk(clk), .rst_n(rst_n),
        .wr_frame_i(wr_frame_i), .rd_frame_i(rd_frame_i),
        .wr_ofs_i(wr_ofs_i), .rd_ofs_i(rd_ofs_i),
        .wr_ptr_o(wr_ptr_o), .rd_ptr_o(rd_ptr_o),
        .wr_addr_o(wr_addr_o), .rd_addr_o(rd_addr_o),
        .ovf_o(ovf_o), .rd_valid_o(rd_valid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_state(string tag);
        check({tag, " R1 wr_ptr"}, int'(wr_ptr_o), m_wr);
        check({tag, " R2 rd_ptr"}, int'(rd_ptr_o), m_rd);
        check({tag, " R4 ovf"}, int'(ovf_o), m_ovf);
        check({tag, " R5 rd_valid"}, int'(rd_valid_o), m_mark[m_rd]);
    endtask

    // One edge: drive at the falling edge, check addresses, update model, check after the edge.
    task automatic step(bit w, bit r, int wo, int ro, string tag);
        int nw, nr, lead;
        bit rel;
        wr_frame_i = w;
        rd_frame_i = r;
        wr_ofs_i   = FPG_OFS_W'(wo);
        rd_ofs_i   = FPG_OFS_W'(ro);
        #1;
        check({tag, " R6 wr_addr"}, int'(wr_addr_o), m_wr * 32 + wo);
        check({tag, " R6 rd_addr"}, int'(rd_addr_o), m_rd * 32 + ro);
        nw   = (m_wr + int'(w)) % 16;
        nr   = (m_rd + int'(r)) % 16;
        lead = (nw - nr + 16) % 16;
        rel  = (lead > 14);
        if (w) m_mark[m_wr] = 1;
        if (r) m_mark[m_rd] = 0;
        if (rel) foreach (m_mark[k]) m_mark[k] = 0;
        if (rel) m_ovf = 1;
        else if (w) m_ovf = 0;
        m_wr = rel ? nr : nw; // R3 / R8
        m_rd = nr;
        @(posedge clk);
        @(negedge clk);
        check_state(tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int ofs;
        m_wr = 8; m_rd = 0; m_ovf = 0;
        foreach (m_mark[k]) m_mark[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R7: reset state
        check("R7 wr_ptr reset", int'(wr_ptr_o), 8);
        check("R7 rd_ptr reset", int'(rd_ptr_o), 0);
        check("R7 ovf reset", int'(ovf_o), 0);
        check("R7 rd_valid reset", int'(rd_valid_o), 0);
        ofs = 0;
        // Writer laps reader: lead 8 -> 14, then 15 forces reload (R3, R4).
        for (int i = 0; i < 24; i++) begin
            step(1'b1, 1'b0, ofs % 32, (ofs * 7) % 32, "wr-run");
            ofs++;
        end
        // Idle: overflow must hold without a write strobe (R4).
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, i, 31 - i, "idle");
        // Reader overtakes writer: lead drops through 0 to 15 (R3, R5).
        for (int i = 0; i < 24; i++) begin
            step(1'b0, 1'b1, (ofs * 3) % 32, ofs % 32, "rd-run");
            ofs++;
        end
        // Simultaneous strobes keep the lead (R8).
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, i, i, "both");
        // Fill a few frames then drain them to see marks survive (R5).
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, i, i, "fill");
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, i, i, "drain");
        // Biased pseudo-random traffic in three regimes.
        for (int seg = 0; seg < 3; seg++) begin
            for (int i = 0; i < 3000; i++) begin
                bit w, r;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                w = (seg == 0) ? (lfsr[1:0] != 2'b00) : lfsr[0];
                r = (seg == 1) ? (lfsr[3:2] != 2'b00) : lfsr[4];
                step(w, r, int'(lfsr[9:5]), int'(lfsr[15:11]), "random");
            end
        end
        finish_run();
    end

endmodule